// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is a single compare/capture channel that sits beside a free-running timer counter. A 4-bit I/O control word decides its role. In compare role the channel drives an output pin. Writing the control word sets the pin to a chosen starting level. After that, each counter match drives the pin low, drives it high or toggles it. In capture role the channel copies the counter value into its general register. The copy is triggered either by a chosen edge of a synchronized input pin or by count events of a cascaded neighbouring counter.

Software reaches the channel through a small write port with three targets: the control word, the general register, and a sticky match/capture flag. A buffer-mode input marks the general register as serving as a buffer for another register. While it is high, the channel produces neither matches nor captures.

Top module: `tcc_channel`

## Requirements
- R1: After a synchronous reset, the general register reads 0, the control word is 0, the pin level is 0, the output enable is 0 and the flag is 0.
- R2: Control word encoding is: bit 3 is the role (0 compare, 1 capture), bit 2 is the starting level in compare role, and bits 1:0 are the action. Writing the word (`wr_sel`=0, data bits 3:0) with bit 3 clear sets the pin to bit 2 on the same clock edge.
- R3: In compare role a match drives the pin on the next edge. Action 01 drives 0, action 10 drives 1 and action 11 inverts the pin.
- R4: A match needs `cnt_en` high together with `cnt_val` equal to the general register. Without `cnt_en` the pin and the flag do not change.
- R5: In capture role with bit 2 clear, the pin passes through two synchronizing flops. Mode 00 captures on a rising edge, 01 on a falling edge, and 10 or 11 on both edges. The counter value is latched on the third clock edge after the pin changes.
- R6: In capture role with bit 2 set, bits 1:0 are ignored and each `nbr_evt` pulse latches the counter value on the next edge. No capture occurs while `nbr_undiv` is high.
- R7: While `buf_mode` is high, the channel produces no match and no capture: the pin, the flag and the general register keep their values.
- R8: Each match or capture sets the flag. The flag stays set until a write to `wr_sel`=2 with data bit 0 clear. A set in the same cycle wins over that clear.
- R9: Software writes to the general register (`wr_sel`=1) take effect on the next edge. A capture in the same cycle wins over the write.
- R10: The output enable is 0 in capture role and when the action is 00. In that case a match still sets the flag but leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Current timer counter value |
| cnt_en | input | 1 | Counter advances this cycle |
| pin_in | input | 1 | Asynchronous capture pin |
| nbr_evt | input | 1 | Count event strobe of the cascaded neighbour counter |
| nbr_undiv | input | 1 | Neighbour counter runs on the undivided clock |
| buf_mode | input | 1 | General register is serving as a buffer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 general register, 2 flag |
| wr_data | input | 16 | Write data |
| gr_q | output | 16 | General register contents |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| flag | output | 1 | Sticky match/capture flag |

## Verification
Two cases can fall on the same clock. A neighbour-triggered capture can meet a software write to the general register. The bench drives `nbr_evt` and a general-register write in one cycle and expects the captured counter value, not the written data. A compare match can also meet a flag-clear write. The bench pairs a matching `cnt_en` cycle with a flag write of 0 and expects the flag to stay set. Each case is then repeated alone to show that the losing operation works when it has no rival.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef struct packed {
        logic       cap;   // role: 0 compare, 1 capture
        logic       sel;   // compare: starting level; capture: neighbour source
        logic [1:0] mode;  // compare action or capture edge choice
    } ioc_t;

    typedef enum logic [1:0] {
        ACT_OFF  = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        SEL_IOC  = 2'd0,
        SEL_GR   = 2'd1,
        SEL_FLAG = 2'd2
    } wsel_e;

    function automatic logic next_level(input logic [1:0] act, input logic cur);
        case (act_e'(act))
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_TGL:  return ~cur;
            default:  return cur;
        endcase
    endfunction

    function automatic logic pin_edge_hit(input logic [1:0] m, input logic r, input logic f);
        case (m)
            2'b00:   return r;
            2'b01:   return f;
            default: return r | f;
        endcase
    endfunction

endpackage

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES;

    logic [TOP:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[TOP-1:0], pin_in};
    end

    assign rise =  sh[TOP-1] & ~sh[TOP];
    assign fall = ~sh[TOP-1] &  sh[TOP];
endmodule

// File: rtl/tcc_trig.sv
module tcc_trig
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  ioc_t         ioc,
    input  logic [W-1:0] cnt_val,
    input  logic [W-1:0] gr,
    input  logic         cnt_en,
    input  logic         rise,
    input  logic         fall,
    input  logic         nbr_evt,
    input  logic         nbr_undiv,
    input  logic         buf_mode,
    output logic         match,
    output logic         cap_fire
);
    logic pin_hit;
    logic nbr_hit;
    logic src_hit;

    always_comb begin
        pin_hit  = pin_edge_hit(ioc.mode, rise, fall);
        nbr_hit  = nbr_evt & ~nbr_undiv;
        src_hit  = ioc.sel ? nbr_hit : pin_hit;
        match    = ~ioc.cap & cnt_en & (cnt_val == gr) & ~buf_mode;
        cap_fire =  ioc.cap & src_hit & ~buf_mode;
    end
endmodule

// File: rtl/tcc_pin_drv.sv
module tcc_pin_drv
    import tcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ioc_wr,
    input  ioc_t ioc_new,
    input  ioc_t ioc,
    input  logic match,
    output logic pin_q,
    output logic oe
);
    always_ff @(posedge clk) begin
        if (rst)                         pin_q <= 1'b0;
        else if (ioc_wr && !ioc_new.cap) pin_q <= ioc_new.sel;
        else if (match)                  pin_q <= next_level(ioc.mode, pin_q);
    end

    assign oe = ~ioc.cap & (ioc.mode != ACT_OFF);

    // R3: toggle action inverts the pin on the edge after a match
    p_toggle_flips_r3: assert property (@(posedge clk) disable iff (rst)
        (match && ioc.mode == ACT_TGL && !ioc_wr) |=> (pin_q != $past(pin_q)));

    // R4: without a match or a control write the pin holds
    p_hold_no_match_r4: assert property (@(posedge clk) disable iff (rst)
        (!match && !ioc_wr) |=> $stable(pin_q));
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_en,
    input  logic         pin_in,
    input  logic         nbr_evt,
    input  logic         nbr_undiv,
    input  logic         buf_mode,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] gr_q,
    output logic         pin_out,
    output logic         pin_oe,
    output logic         flag
);
    localparam int IOC_W = $bits(ioc_t);

    ioc_t ioc_q;
    ioc_t ioc_new;
    logic ioc_wr, gr_wr, flag_clr;
    logic rise, fall, match, cap_fire;

    assign ioc_new  = ioc_t'(wr_data[IOC_W-1:0]);
    assign ioc_wr   = wr_en && (wr_sel == SEL_IOC);
    assign gr_wr    = wr_en && (wr_sel == SEL_GR);
    assign flag_clr = wr_en && (wr_sel == SEL_FLAG) && !wr_data[0];

    tcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .rise(rise), .fall(fall)
    );

    tcc_trig #(.W(W)) u_trig (
        .ioc(ioc_q), .cnt_val(cnt_val), .gr(gr_q), .cnt_en(cnt_en),
        .rise(rise), .fall(fall), .nbr_evt(nbr_evt), .nbr_undiv(nbr_undiv),
        .buf_mode(buf_mode), .match(match), .cap_fire(cap_fire)
    );

    tcc_pin_drv u_drv (
        .clk(clk), .rst(rst), .ioc_wr(ioc_wr), .ioc_new(ioc_new),
        .ioc(ioc_q), .match(match), .pin_q(pin_out), .oe(pin_oe)
    );

    always_ff @(posedge clk) begin
        if (rst)         ioc_q <= '0;
        else if (ioc_wr) ioc_q <= ioc_new;
    end

    always_ff @(posedge clk) begin
        if (rst)           gr_q <= '0;
        else if (cap_fire) gr_q <= cnt_val;
        else if (gr_wr)    gr_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)                   flag <= 1'b0;
        else if (match | cap_fire) flag <= 1'b1;
        else if (flag_clr)         flag <= 1'b0;
    end

    // R9: a capture loads the counter value even against a software write
    p_capture_wins_r9: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> (gr_q == $past(cnt_val)));

    // R8: the flag only falls through an explicit clear
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    // R7: buffer mode leaves the general register to software only
    p_buf_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (buf_mode && !gr_wr) |=> $stable(gr_q));

    // R10: capture role never enables the pin driver
    p_no_oe_capture_r10: assert property (@(posedge clk) disable iff (rst)
        ioc_q.cap |-> !pin_oe);
endmodule

// File: tb/tb_tcc_channel.sv
`timescale 1ns/1ps
module tb_tcc_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = '0;
    logic        cnt_en = 1'b0;
    logic        pin_in = 1'b0;
    logic        nbr_evt = 1'b0;
    logic        nbr_undiv = 1'b0;
    logic        buf_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] gr_q;
    logic        pin_out, pin_oe, flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tcc_channel dut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_en(cnt_en),
        .pin_in(pin_in), .nbr_evt(nbr_evt), .nbr_undiv(nbr_undiv),
        .buf_mode(buf_mode), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .gr_q(gr_q), .pin_out(pin_out),
        .pin_oe(pin_oe), .flag(flag)
    );

    typedef struct packed {
        logic [3:0]  ioc;
        logic [15:0] gr;
        logic [15:0] cnt;
        logic        en;
        logic        pin;
        logic        oe;
        logic        flg;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 16'h0040, 16'h0040, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'b0101, 16'h0041, 16'h0041, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'b0010, 16'h0042, 16'h0042, 1'b1, 1'b1, 1'b1, 1'b1},
        '{4'b0110, 16'h0043, 16'h0043, 1'b1, 1'b1, 1'b1, 1'b1},
        '{4'b0011, 16'h0044, 16'h0044, 1'b1, 1'b1, 1'b1, 1'b1},
        '{4'b0111, 16'h0045, 16'h0045, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'b0011, 16'h0046, 16'h0047, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'b0111, 16'h0048, 16'h0048, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'b0100, 16'h0049, 16'h0049, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 gr", gr_q, 16'h0);
        chk("R1 pin", {15'b0, pin_out}, 16'h0);
        chk("R1 oe", {15'b0, pin_oe}, 16'h0);
        chk("R1 flag", {15'b0, flag}, 16'h0);

        // R2 R3 R4 R10 compare vectors
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, {12'b0, VECS[i].ioc});
            chk("R2 start level", {15'b0, pin_out}, {15'b0, VECS[i].ioc[2]});
            wr(2'd1, VECS[i].gr);
            wr(2'd2, 16'h0);
            cnt_val = VECS[i].cnt; cnt_en = VECS[i].en;
            step(1);
            cnt_en = 1'b0;
            chk("R3 R4 R10 pin", {15'b0, pin_out}, {15'b0, VECS[i].pin});
            chk("R10 oe", {15'b0, pin_oe}, {15'b0, VECS[i].oe});
            chk("R4 R8 flag", {15'b0, flag}, {15'b0, VECS[i].flg});
        end

        // R5 rising edge capture, latched on third edge
        wr(2'd0, 16'h0008);
        wr(2'd2, 16'h0);
        chk("R10 oe capture", {15'b0, pin_oe}, 16'h0);
        cnt_val = 16'h1234;
        pin_in = 1'b1;
        step(2);
        chk("R5 not yet", gr_q, 16'h0049);
        step(1);
        chk("R5 rise", gr_q, 16'h1234);
        chk("R5 R8 flag", {15'b0, flag}, 16'h1);

        // R5 falling edge mode
        wr(2'd0, 16'h0009);
        wr(2'd2, 16'h0);
        cnt_val = 16'h2222; pin_in = 1'b0;
        step(3);
        chk("R5 fall", gr_q, 16'h2222);
        wr(2'd2, 16'h0);
        cnt_val = 16'h3333; pin_in = 1'b1;
        step(4);
        chk("R5 fall ignores rise", gr_q, 16'h2222);
        chk("R5 no flag on rise", {15'b0, flag}, 16'h0);

        // R5 both edges
        wr(2'd0, 16'h000A);
        cnt_val = 16'h4444; pin_in = 1'b0;
        step(3);
        chk("R5 both fall", gr_q, 16'h4444);
        cnt_val = 16'h5555; pin_in = 1'b1;
        step(3);
        chk("R5 both rise", gr_q, 16'h5555);

        // R6 neighbour trigger, low bits ignored
        wr(2'd0, 16'h000F);
        wr(2'd2, 16'h0);
        cnt_val = 16'h6666; nbr_evt = 1'b1;
        step(1);
        nbr_evt = 1'b0;
        chk("R6 neighbour", gr_q, 16'h6666);
        wr(2'd2, 16'h0);
        nbr_undiv = 1'b1; cnt_val = 16'h7777; nbr_evt = 1'b1;
        step(1);
        nbr_evt = 1'b0; nbr_undiv = 1'b0;
        chk("R6 undivided blocked", gr_q, 16'h6666);
        chk("R6 undivided flag", {15'b0, flag}, 16'h0);

        // R7 buffer mode blocks capture and match
        buf_mode = 1'b1;
        cnt_val = 16'h7878; nbr_evt = 1'b1;
        step(1);
        nbr_evt = 1'b0;
        chk("R7 no capture", gr_q, 16'h6666);
        wr(2'd0, 16'h0002);
        wr(2'd1, 16'h0010);
        wr(2'd2, 16'h0);
        cnt_val = 16'h0010; cnt_en = 1'b1;
        step(1);
        cnt_en = 1'b0;
        chk("R7 no match pin", {15'b0, pin_out}, 16'h0);
        chk("R7 no match flag", {15'b0, flag}, 16'h0);
        buf_mode = 1'b0;

        // R9 capture beats software write
        wr(2'd0, 16'h000C);
        cnt_val = 16'h8888; nbr_evt = 1'b1;
        wr(2'd1, 16'h9999);
        nbr_evt = 1'b0;
        chk("R9 capture wins", gr_q, 16'h8888);
        wr(2'd1, 16'hAAAA);
        chk("R9 write alone", gr_q, 16'hAAAA);

        // R8 set beats clear, then clear alone
        wr(2'd0, 16'h0003);
        wr(2'd1, 16'h0005);
        wr(2'd2, 16'h0);
        cnt_val = 16'h0005; cnt_en = 1'b1;
        wr(2'd2, 16'h0);
        cnt_en = 1'b0;
        chk("R8 set wins", {15'b0, flag}, 16'h1);
        wr(2'd2, 16'h0001);
        chk("R8 write one keeps", {15'b0, flag}, 16'h1);
        wr(2'd2, 16'h0);
        chk("R8 clear", {15'b0, flag}, 16'h0);

        summary();
    end
endmodule